// File: doc/BRIEF.md
# Dual-Mode Programmable Frequency Divider

This block divides a local-oscillator clock by a programmed divisor. It produces one output pulse for every completed division cycle, and that pulse serves as the feedback clock of a phase-locked loop. Two control bits choose between two paths. The first is a pulse-swallow chain: a 16/17 dual-modulus prescaler, a swallow counter loaded from the four low divisor bits, and a main counter loaded from the twelve upper bits. The second is a direct 12-bit down-counter.

The active path and the divisor are captured only at the end of a division cycle. A change written in the middle of a cycle therefore waits until the running cycle completes, so the output never carries a shortened pulse interval. Each path has its own legal divisor range. When the captured divisor falls outside the range of its path, the valid flag drops and the output stays low. While the flag is low the block samples its inputs on every cycle, so a legal word written afterwards starts a new division cycle at once.

Top module: `dual_mode_divider`

## Requirements
- R1: During and directly after reset, `div_valid` is 0 and `div_out` is 0.
- R2: With `band_sel` = 1 the pulse-swallow path is used whatever `sw_mode` holds. For example, a divisor of 5000 is legal and gives a period of 5000.
- R3: With `band_sel` = 0 and `sw_mode` = 1 the pulse-swallow path is used. A divisor of 100 is illegal here and 272 is legal.
- R4: With `band_sel` = 0 and `sw_mode` = 0 the direct path is used. A divisor of 5000 is illegal here and 300 is legal.
- R5: On the pulse-swallow path, divisors from 272 to 65535 are legal. The distance between successive `div_out` pulses equals the divisor in input clock cycles, including at 272 and at 65535.
- R6: On the direct path, divisors from 5 to 4095 are legal. The pulse distance equals the divisor, including at 5 and at 4095.
- R7: An out-of-range divisor for the selected path makes `div_valid` 0 in the cycle after it is captured. `div_out` then stays 0 for as long as the configuration remains illegal.
- R8: Divisor and path inputs are captured only on the clock edge that ends a division cycle. A cycle already in progress completes with its old divisor, and the following cycle uses the new one.
- R9: `div_out` is high for exactly one input clock cycle per division cycle.
- R10: `div_valid` changes only on the edge that ends a division cycle, or while it is 0. While it is 0, a legal configuration on the inputs sets it to 1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-oscillator clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_word | input | 16 | Divisor word; low 4 bits are the swallow count and upper 12 bits the main count in pulse-swallow mode, low 12 bits are the count in direct mode |
| band_sel | input | 1 | 1 selects the high-band input (always the pulse-swallow path), 0 the low-band input |
| sw_mode | input | 1 | Low band only: 1 selects the pulse-swallow path, 0 the direct path |
| div_out | output | 1 | One-cycle pulse at the end of each division cycle |
| div_valid | output | 1 | 1 when the captured divisor is legal for the captured path |

## Verification
Several properties are checked on every cycle: the output stays quiet while the flag is low, each pulse lasts one cycle, the flag can change only at a cycle boundary, a legal word is picked up straight away while the flag is low, and pulses are never closer together than the smallest direct divisor. Other behaviour can only be shown by the bench scenarios. These are the exact pulse period at each end of both ranges, the choice of path made by the two select bits, the rejection of words just outside each range, and a divisor rewritten mid-cycle that must leave the running cycle at its old length.

// File: rtl/lodiv_pkg.sv
package lodiv_pkg;

    localparam int WORD_W   = 16;
    localparam int PRE_BITS = 4;
    localparam int DIR_W    = 12;
    localparam int DIR_MIN  = 5;

    localparam int PRE_MOD  = 1 << PRE_BITS;
    localparam int MAIN_W   = WORD_W - PRE_BITS;
    localparam int SWL_MIN  = PRE_MOD * (PRE_MOD + 1);
    localparam int DIR_LIM  = 1 << DIR_W;

    localparam logic [WORD_W-1:0] SWL_MIN_W = WORD_W'(SWL_MIN);
    localparam logic [WORD_W-1:0] DIR_MIN_W = WORD_W'(DIR_MIN);
    localparam logic [WORD_W-1:0] DIR_LIM_W = WORD_W'(DIR_LIM);

    typedef enum logic {
        PATH_DIRECT  = 1'b0,
        PATH_SWALLOW = 1'b1
    } path_e;

    typedef struct packed {
        path_e             path;
        logic [WORD_W-1:0] word;
    } div_cfg_t;

    function automatic path_e pick_path(input logic band, input logic mode);
        return (band | mode) ? PATH_SWALLOW : PATH_DIRECT;
    endfunction

    function automatic logic cfg_legal(input div_cfg_t c);
        if (c.path == PATH_SWALLOW)
            return c.word >= SWL_MIN_W;
        return (c.word >= DIR_MIN_W) && (c.word < DIR_LIM_W);
    endfunction

endpackage

// File: rtl/div_prescale.sv
module div_prescale #(
    parameter int PRE_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_wide,
    input  logic wide_next,
    output logic wrap
);
    localparam int PC_W = PRE_BITS + 1;
    localparam logic [PC_W-1:0] CNT_NARROW = PC_W'((1 << PRE_BITS) - 1);
    localparam logic [PC_W-1:0] CNT_WIDE   = PC_W'(1 << PRE_BITS);

    logic [PC_W-1:0] pc_q;

    assign wrap = (pc_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (load)
            pc_q <= load_wide ? CNT_WIDE : CNT_NARROW;
        else if (wrap)
            pc_q <= wide_next ? CNT_WIDE : CNT_NARROW;
        else
            pc_q <= pc_q - 1'b1;
    end
endmodule

// File: rtl/div_swallow_path.sv
module div_swallow_path
    import lodiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              term
);
    logic [PRE_BITS-1:0] swl_q, swl_next;
    logic [MAIN_W-1:0]   main_q;
    logic                wrap;

    assign swl_next = (swl_q != '0) ? swl_q - 1'b1 : '0;

    div_prescale #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_wide (word[PRE_BITS-1:0] != '0),
        .wide_next (swl_next != '0),
        .wrap      (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            swl_q  <= '0;
            main_q <= '0;
        end else if (load) begin
            swl_q  <= word[PRE_BITS-1:0];
            main_q <= word[WORD_W-1:PRE_BITS];
        end else if (wrap) begin
            swl_q  <= swl_next;
            main_q <= main_q - 1'b1;
        end
    end

    assign term = wrap && (main_q == MAIN_W'(1));
endmodule

// File: rtl/div_direct_path.sv
module div_direct_path #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] word,
    output logic             term
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= word - 1'b1;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign term = (cnt_q == '0);
endmodule

// File: rtl/dual_mode_divider.sv
module dual_mode_divider
    import lodiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] div_word,
    input  logic              band_sel,
    input  logic              sw_mode,
    output logic              div_out,
    output logic              div_valid
);
    div_cfg_t cfg_in;
    path_e    path_q;
    logic     ok_q;
    logic     swl_term, dir_term, term_act, restart;

    assign cfg_in.path = pick_path(band_sel, sw_mode);
    assign cfg_in.word = div_word;

    assign term_act = (path_q == PATH_SWALLOW) ? swl_term : dir_term;
    assign restart  = !ok_q || term_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= PATH_DIRECT;
            ok_q   <= 1'b0;
        end else if (restart) begin
            path_q <= cfg_in.path;
            ok_q   <= cfg_legal(cfg_in);
        end
    end

    div_swallow_path u_swl (
        .clk  (clk),
        .rst  (rst),
        .load (restart),
        .word (div_word),
        .term (swl_term)
    );

    div_direct_path #(.CNT_W(DIR_W)) u_dir (
        .clk  (clk),
        .rst  (rst),
        .load (restart),
        .word (div_word[DIR_W-1:0]),
        .term (dir_term)
    );

    assign div_out   = ok_q && term_act;
    assign div_valid = ok_q;
endmodule

// File: rtl/lodiv_checker.sv
module lodiv_checker
    import lodiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] div_word,
    input logic              band_sel,
    input logic              sw_mode,
    input logic              div_out,
    input logic              div_valid
);
    logic [WORD_W-1:0] gap_q;
    logic              seen_q;
    div_cfg_t          in_cfg;

    assign in_cfg.path = pick_path(band_sel, sw_mode);
    assign in_cfg.word = div_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_out) begin
            gap_q  <= WORD_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!div_out && !div_valid));

    a_r7_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
        !div_valid |-> !div_out);

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    a_r10_valid_holds: assert property (@(posedge clk) disable iff (rst)
        (div_valid && !div_out) |=> div_valid);

    a_r10_pickup: assert property (@(posedge clk) disable iff (rst)
        (!div_valid && cfg_legal(in_cfg)) |=> div_valid);

    a_r6_min_gap: assert property (@(posedge clk) disable iff (rst)
        (div_out && seen_q) |-> (gap_q >= DIR_MIN_W));
endmodule

bind dual_mode_divider lodiv_checker chk (
    .clk       (clk),
    .rst       (rst),
    .div_word  (div_word),
    .band_sel  (band_sel),
    .sw_mode   (sw_mode),
    .div_out   (div_out),
    .div_valid (div_valid)
);

// File: tb/dual_mode_divider_test.sv
module dual_mode_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] div_word = '0;
    logic        band_sel = 1'b0;
    logic        sw_mode = 1'b0;
    logic        div_out;
    logic        div_valid;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    logic prev_out = 1'b0;

    dual_mode_divider uut (
        .clk       (clk),
        .rst       (rst),
        .div_word  (div_word),
        .band_sel  (band_sel),
        .sw_mode   (sw_mode),
        .div_out   (div_out),
        .div_valid (div_valid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit exp_legal(input logic b, input logic m, input int w);
        if (b || m) return (w >= 272) && (w <= 65535);
        return (w >= 5) && (w <= 4095);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R9: pulse width monitor, sampled at negedge
    always @(negedge clk) begin
        if (!rst && div_out) begin
            checks++;
            if (prev_out) begin
                errors++;
                $display("FAIL R9: actual width>1 expected 1");
            end
        end
        prev_out = div_out;
    end

    task automatic wait_pulse(output int t);
        t = -1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (div_out) begin
                t = cyc;
                break;
            end
        end
        if (t < 0) begin
            t = cyc;
            check(1'b0, "pulse-timeout", 0, 1);
        end
    endtask

    task automatic apply(input logic b, input logic m, input int w);
        band_sel = b;
        sw_mode  = m;
        div_word = 16'(w);
    endtask

    // called at a pulse negedge; new settings are captured at this boundary
    task automatic measure(input logic b, input logic m, input int w, input string req);
        int t0, t1;
        apply(b, m, w);
        t0 = cyc;
        wait_pulse(t1);
        check((t1 - t0) == w, req, t1 - t0, w);
    endtask

    // called at a pulse negedge; ends at a pulse negedge of a legal direct-7 run
    task automatic reject(input logic b, input logic m, input int w, input string req);
        int hits, ta, tb;
        apply(b, m, w);
        @(negedge clk);
        check(div_valid == 1'b0, req, int'(div_valid), 0);
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (div_out) hits++;
        end
        check(hits == 0, "R7 quiet", hits, 0);
        apply(1'b0, 1'b0, 7);
        @(negedge clk);
        check(div_valid == 1'b1, "R10 pickup", int'(div_valid), 1);
        wait_pulse(ta);
        wait_pulse(tb);
        check((tb - ta) == 7, "R10 restart period", tb - ta, 7);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t, ta, tb;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        check(div_valid == 1'b0 && div_out == 1'b0, "R1 in reset", int'({div_valid, div_out}), 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(div_valid == 1'b0 && div_out == 1'b0, "R1 after reset", int'({div_valid, div_out}), 0);

        apply(1'b0, 1'b0, 5);
        @(negedge clk);
        check(div_valid == 1'b1, "R10 pickup after reset", int'(div_valid), 1);
        wait_pulse(t);

        measure(1'b0, 1'b0, 5,     "R6 direct min");
        measure(1'b0, 1'b0, 4095,  "R6 direct max");
        measure(1'b0, 1'b0, 300,   "R4 direct 300");
        measure(1'b1, 1'b0, 272,   "R5 swallow min (R2 band)");
        measure(1'b1, 1'b0, 5000,  "R2 band high 5000");
        measure(1'b1, 1'b1, 1000,  "R2 band high with mode set");
        measure(1'b0, 1'b1, 272,   "R3 low band swallow");
        measure(1'b0, 1'b1, 65535, "R5 swallow max");
        measure(1'b0, 1'b0, 50,    "R8 setup");

        // R8: rewrite mid-cycle; running cycle keeps the old divisor
        repeat (10) @(negedge clk);
        apply(1'b0, 1'b0, 20);
        wait_pulse(ta);
        check((ta - t) >= 0, "R8 sync", ta - t, ta - t);
        wait_pulse(tb);
        check((tb - ta) == 20, "R8 new divisor next cycle", tb - ta, 20);
        repeat (3) @(negedge clk);
        apply(1'b1, 1'b0, 400);
        wait_pulse(ta);
        wait_pulse(tb);
        check((tb - ta) == 400, "R8 path change at boundary", tb - ta, 400);
        measure(1'b0, 1'b0, 20, "R8 realign");
        repeat (4) @(negedge clk);
        apply(1'b0, 1'b0, 9);
        t = cyc;
        wait_pulse(ta);
        check((ta - t) == 16, "R8 old cycle completes", ta - t, 16);

        reject(1'b0, 1'b0, 4,     "R7 direct below min");
        reject(1'b0, 1'b0, 4096,  "R7 direct above max");
        reject(1'b0, 1'b0, 5000,  "R4 direct rejects 5000");
        reject(1'b1, 1'b0, 271,   "R7 swallow below min");
        reject(1'b0, 1'b1, 100,   "R3 swallow rejects 100");

        for (int k = 0; k < 16; k++) begin
            int sel, w;
            logic b, m;
            sel = $urandom_range(0, 2);
            if (sel == 0) begin
                b = 1'b1; m = 1'($urandom_range(0, 1)); w = $urandom_range(272, 900);
            end else if (sel == 1) begin
                b = 1'b0; m = 1'b1; w = $urandom_range(272, 900);
            end else begin
                b = 1'b0; m = 1'b0; w = $urandom_range(5, 600);
            end
            if (exp_legal(b, m, w))
                measure(b, m, w, (sel == 2) ? "R6 random direct" : "R5 random swallow");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule